// File: doc/BRIEF.md
# Triggered DMA Request Generator

This block is a single generator channel that turns an edge on one chosen trigger line into a counted burst of DMA requests. Software sets up a 32-bit control word that picks the trigger line, the kind of edge that counts as an event, how many requests a burst holds and whether the channel is enabled. When an event arrives on an idle, enabled channel, the block issues `count + 1` requests over a valid/ready handshake toward the request router and then waits for the next event.

A trigger event that lands while a burst is still in progress neither restarts nor lengthens that burst. It sets a sticky overrun flag instead. The flag is cleared by a one-cycle write with a 1 in bit 0 of the clear port. An interrupt line reports the flag when the overrun interrupt enable is set. Clearing the channel enable stops any burst at once and drops the request.

Back-pressure rules on the request stream: `req_valid` stays high until the cycle in which `req_ready` is also high. That cycle is the handshake. The valid signal is low in the cycle after every handshake. The router may hold `req_ready` low for any number of cycles. The only thing that withdraws a pending request is clearing the channel enable.

Top module: `trig_burst_gen`

## Requirements
- R1: After reset, `req_valid`, `ovr_flag` and `irq` are 0 and `cfg_rdata` reads 0.
- R2: The control word layout, written through `cfg_we`/`cfg_wdata` and read back on `cfg_rdata` one cycle later, is: trigger select in bits 4:0, overrun interrupt enable in bit 8, channel enable in bit 16, edge mode in bits 18:17, burst count in bits 23:19. All other bits read as 0.
- R3: A write replaces the burst count only if the channel enable was 0 before that write. Otherwise the count keeps its old value and the other fields still update.
- R4: The edge mode selects which transitions of the chosen line are events: 0 means none, 1 means low-to-high, 2 means high-to-low, 3 means both.
- R5: An event on an idle, enabled channel starts a burst of exactly `count + 1` handshakes, after which no request is raised until a new event.
- R6: A raised `req_valid` stays high until a handshake. After each handshake `req_valid` is low for at least one cycle. The next request of the burst follows in the cycle after that.
- R7: An event during an active burst does not change the number of requests in that burst, and it sets `ovr_flag` one cycle later.
- R8: `ovr_flag` stays set until a cycle with `clr_we` high and `clr_wdata[0]` = 1 clears it. A clear write with bit 0 = 0 has no effect. A new overrun in the same cycle as a clear wins.
- R9: `irq` is high exactly when `ovr_flag` is set and the overrun interrupt enable is 1.
- R10: With the channel enable at 0, any burst is aborted, `req_valid` drops within two cycles of the disabling write, and trigger transitions start nothing.
- R11: Only the trigger line whose index equals the select field can produce events. A select value at or above `NUM_TRIG` selects a constant 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_in | input | NUM_TRIG | Trigger lines, already synchronous to clk |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Control word readback |
| clr_we | input | 1 | Overrun clear write strobe |
| clr_wdata | input | 32 | Clear data; bit 0 = 1 clears the overrun flag |
| req_valid | output | 1 | DMA request toward the router |
| req_ready | input | 1 | Router accepts the request |
| ovr_flag | output | 1 | Sticky overrun status |
| irq | output | 1 | Overrun interrupt |

## Verification
The assertions assume that the trigger lines and `req_ready` are already synchronous to `clk`. They also assume that software does not change the select field while the newly chosen line differs from the old one, because that change would itself look like an edge. The stimulus changes every input only at the falling clock edge. It lowers a line before switching the select onto it, and it reconfigures the edge mode and count only while the channel is disabled. Under these conditions the behavioural reference model and the design see the same events.

// File: rtl/tbg_pkg.sv
package tbg_pkg;
  localparam int WORD_W   = 32;
  localparam int SEL_W    = 5;
  localparam int CNT_W    = 5;
  localparam int POS_SEL  = 0;
  localparam int POS_IE   = 8;
  localparam int POS_EN   = 16;
  localparam int POS_EDGE = 17;
  localparam int POS_CNT  = 19;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_mode_e;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             ie;
    logic             en;
    edge_mode_e       mode;
    logic [CNT_W-1:0] count;
  } gen_cfg_t;
endpackage

// File: rtl/tbg_ctrl_reg.sv
module tbg_ctrl_reg
  import tbg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output gen_cfg_t          cfg,
  output logic [WORD_W-1:0] rdata
);
  gen_cfg_t cfg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr_en) begin
      cfg_q.sel  <= wr_data[POS_SEL +: SEL_W];
      cfg_q.ie   <= wr_data[POS_IE];
      cfg_q.en   <= wr_data[POS_EN];
      cfg_q.mode <= edge_mode_e'(wr_data[POS_EDGE +: 2]);
      if (!cfg_q.en) begin
        cfg_q.count <= wr_data[POS_CNT +: CNT_W];
      end
    end
  end

  always_comb begin
    rdata = '0;
    rdata[POS_SEL +: SEL_W]  = cfg_q.sel;
    rdata[POS_IE]            = cfg_q.ie;
    rdata[POS_EN]            = cfg_q.en;
    rdata[POS_EDGE +: 2]     = cfg_q.mode;
    rdata[POS_CNT +: CNT_W]  = cfg_q.count;
  end

  assign cfg = cfg_q;

  // R3: the burst count cannot move while the channel is enabled
  a_r3_count_locked: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.en |=> $stable(cfg_q.count));
endmodule

// File: rtl/tbg_trig_edge.sv
module tbg_trig_edge
  import tbg_pkg::*;
#(
  parameter int NUM_TRIG = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_TRIG-1:0] trig_in,
  input  logic [SEL_W-1:0]    sel,
  input  edge_mode_e          mode,
  input  logic                en,
  output logic                evt
);
  logic [NUM_TRIG-1:0] hit;
  logic                line_now;
  logic                line_prev;

  for (genvar i = 0; i < NUM_TRIG; i++) begin : g_sel
    assign hit[i] = trig_in[i] && (sel == SEL_W'(i));
  end

  assign line_now = |hit;

  always_ff @(posedge clk) begin
    if (!rst_n) line_prev <= 1'b0;
    else        line_prev <= line_now;
  end

  always_comb begin
    unique case (mode)
      EDGE_RISE: evt = en && line_now && !line_prev;
      EDGE_FALL: evt = en && !line_now && line_prev;
      EDGE_BOTH: evt = en && (line_now != line_prev);
      default:   evt = 1'b0;
    endcase
  end

  // R10: no event is reported while the channel is disabled
  a_r10_no_evt_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !evt);
endmodule

// File: rtl/tbg_burst.sv
module tbg_burst
  import tbg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] count,
  input  logic             evt,
  input  logic             clr,
  input  logic             req_ready,
  output logic             req_valid,
  output logic             ovr
);
  logic             active;
  logic [CNT_W-1:0] done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      req_valid <= 1'b0;
      done      <= '0;
    end else if (!en) begin
      active    <= 1'b0;
      req_valid <= 1'b0;
      done      <= '0;
    end else if (active) begin
      if (req_valid) begin
        if (req_ready) begin
          req_valid <= 1'b0;
          if (done == count) active <= 1'b0;
          else               done   <= done + 1'b1;
        end
      end else begin
        req_valid <= 1'b1;
      end
    end else if (evt) begin
      active    <= 1'b1;
      req_valid <= 1'b1;
      done      <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)               ovr <= 1'b0;
    else if (evt && active)   ovr <= 1'b1;
    else if (clr)             ovr <= 1'b0;
  end

  // R6: a pending request is held until accepted
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && en) |=> req_valid);
  // R6: one idle cycle follows each handshake
  a_r6_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_valid);
  // R10: disabled channel drops the request
  a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !req_valid);
  // R5: issued-request counter never passes the programmed count
  a_r5_bound: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (done <= count));
  // R7: an event during a burst raises the overrun flag
  a_r7_set: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && active) |=> ovr);
  // R8: the flag is sticky without a clear
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !clr) |=> ovr);
endmodule

// File: rtl/trig_burst_gen.sv
module trig_burst_gen
  import tbg_pkg::*;
#(
  parameter int NUM_TRIG = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_TRIG-1:0] trig_in,
  input  logic                cfg_we,
  input  logic [31:0]         cfg_wdata,
  output logic [31:0]         cfg_rdata,
  input  logic                clr_we,
  input  logic [31:0]         clr_wdata,
  output logic                req_valid,
  input  logic                req_ready,
  output logic                ovr_flag,
  output logic                irq
);
  gen_cfg_t cfg;
  logic     evt;
  logic     clr;

  tbg_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_data (cfg_wdata),
    .cfg     (cfg),
    .rdata   (cfg_rdata)
  );

  tbg_trig_edge #(.NUM_TRIG(NUM_TRIG)) u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .trig_in (trig_in),
    .sel     (cfg.sel),
    .mode    (cfg.mode),
    .en      (cfg.en),
    .evt     (evt)
  );

  assign clr = clr_we && clr_wdata[0];

  tbg_burst u_burst (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (cfg.en),
    .count     (cfg.count),
    .evt       (evt),
    .clr       (clr),
    .req_ready (req_ready),
    .req_valid (req_valid),
    .ovr       (ovr_flag)
  );

  assign irq = ovr_flag && cfg.ie;

  // R9: interrupt never fires with the enable bit of the readback clear
  a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cfg_rdata[POS_IE] && ovr_flag));
endmodule

// File: tb/trig_burst_gen_bench.sv
`timescale 1ns/1ps
module trig_burst_gen_bench;
  localparam int NT = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NT-1:0] trig_in = '0;
  logic          cfg_we = 1'b0;
  logic [31:0]   cfg_wdata = '0;
  logic [31:0]   cfg_rdata;
  logic          clr_we = 1'b0;
  logic [31:0]   clr_wdata = '0;
  logic          req_valid;
  logic          req_ready = 1'b1;
  logic          ovr_flag;
  logic          irq;

  int    errors = 0;
  int    checks = 0;
  int    hs = 0;
  int    cyc = 0;
  int    rdy_mode = 0;
  string phase = "R1";

  // reference model state
  int m_sel = 0, m_ie = 0, m_en = 0, m_edge = 0, m_cnt = 0;
  bit m_prev = 0, m_active = 0, m_valid = 0, m_flag = 0;
  int m_done = 0;

  trig_burst_gen #(.NUM_TRIG(NT)) u_trig_burst_gen (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .clr_we(clr_we), .clr_wdata(clr_wdata),
    .req_valid(req_valid), .req_ready(req_ready),
    .ovr_flag(ovr_flag), .irq(irq)
  );

  always #2.5 clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_word();
    return 32'(m_sel) | (32'(m_ie) << 8) | (32'(m_en) << 16)
         | (32'(m_edge) << 17) | (32'(m_cnt) << 19);
  endfunction

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<50000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
    if (req_valid && req_ready) hs++;
    if (!rst_n) begin
      m_sel = 0; m_ie = 0; m_en = 0; m_edge = 0; m_cnt = 0;
      m_prev = 0; m_active = 0; m_valid = 0; m_flag = 0; m_done = 0;
    end else begin
      bit cur, ev, was_active;
      cur = (m_sel < NT) ? trig_in[m_sel] : 1'b0;
      ev = (m_en != 0) && ((m_edge == 1 && cur && !m_prev) ||
                           (m_edge == 2 && !cur && m_prev) ||
                           (m_edge == 3 && cur != m_prev));
      was_active = m_active;
      if (m_en == 0) begin
        m_active = 0; m_valid = 0; m_done = 0;
      end else if (m_active) begin
        if (m_valid) begin
          if (req_ready) begin
            m_valid = 0;
            if (m_done == m_cnt) m_active = 0;
            else m_done++;
          end
        end else m_valid = 1;
      end else if (ev) begin
        m_active = 1; m_valid = 1; m_done = 0;
      end
      if (ev && was_active) m_flag = 1;
      else if (clr_we && clr_wdata[0]) m_flag = 0;
      m_prev = cur;
      if (cfg_we) begin
        if (m_en == 0) m_cnt = int'(cfg_wdata[23:19]);
        m_sel = int'(cfg_wdata[4:0]); m_ie = int'(cfg_wdata[8]);
        m_en = int'(cfg_wdata[16]); m_edge = int'(cfg_wdata[18:17]);
      end
    end
  end

  // compare on every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk({phase, " req_valid"}, 32'(req_valid), 32'(m_valid));
      chk({phase, " ovr_flag"}, 32'(ovr_flag), 32'(m_flag));
      chk({phase, " irq"}, 32'(irq), 32'(m_flag && m_ie != 0));
      chk({phase, " cfg_rdata"}, cfg_rdata, m_word());
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cfg_we = 1'b0; clr_we = 1'b0;
      req_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? (cyc % 3 == 0) : 1'b0;
    end
  endtask

  task automatic wr_cfg(int sel, int ie, int en, int edge_m, int cnt);
    @(negedge clk);
    cfg_wdata = 32'(sel) | (32'(ie) << 8) | (32'(en) << 16)
              | (32'(edge_m) << 17) | (32'(cnt) << 19);
    cfg_we = 1'b1;
    step(1);
  endtask

  task automatic wr_clr(logic [31:0] d);
    @(negedge clk);
    clr_wdata = d; clr_we = 1'b1;
    step(1);
  endtask

  task automatic set_trig(int idx, logic v);
    @(negedge clk);
    trig_in[idx] = v;
    step(1);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    chk("R1 req_valid", 32'(req_valid), 0);
    chk("R1 ovr_flag", 32'(ovr_flag), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 cfg_rdata", cfg_rdata, 0);

    phase = "R2";
    wr_cfg(3, 1, 0, 1, 2);
    step(1);
    chk("R2 layout", cfg_rdata, 32'h0012_0103);
    wr_cfg(3, 1, 1, 1, 2);
    step(1);
    chk("R2 enable bit", cfg_rdata, 32'h0013_0103);

    phase = "R5"; hs = 0;
    set_trig(3, 1'b1);
    step(20);
    chk("R5 burst of count+1", 32'(hs), 3);
    phase = "R4"; hs = 0;
    set_trig(3, 1'b0);
    step(10);
    chk("R4 falling edge ignored in rise mode", 32'(hs), 0);

    phase = "R3";
    wr_cfg(3, 1, 1, 1, 7);
    step(1);
    chk("R3 count locked while enabled", 32'(cfg_rdata[23:19]), 2);

    phase = "R6"; hs = 0; rdy_mode = 1;
    set_trig(3, 1'b1);
    step(40);
    chk("R6 back-pressured burst length", 32'(hs), 3);
    rdy_mode = 0;

    phase = "R7"; hs = 0;
    set_trig(3, 1'b0);
    set_trig(3, 1'b1);
    set_trig(3, 1'b0);
    set_trig(3, 1'b1);
    step(20);
    chk("R7 burst not extended", 32'(hs), 3);
    chk("R7 overrun set", 32'(ovr_flag), 1);
    chk("R9 irq with enable", 32'(irq), 1);

    phase = "R8";
    wr_clr(32'h0000_0000);
    step(1);
    chk("R8 clear with 0 ignored", 32'(ovr_flag), 1);
    wr_clr(32'h0000_0001);
    step(1);
    chk("R8 clear with 1", 32'(ovr_flag), 0);

    phase = "R9";
    wr_cfg(3, 0, 1, 1, 0);
    set_trig(3, 1'b0);
    set_trig(3, 1'b1);
    set_trig(3, 1'b0);
    set_trig(3, 1'b1);
    step(20);
    chk("R9 flag set", 32'(ovr_flag), 1);
    chk("R9 irq masked", 32'(irq), 0);
    wr_clr(32'h0000_0001);

    phase = "R4";
    wr_cfg(3, 0, 0, 2, 0);
    wr_cfg(3, 0, 1, 2, 0);
    hs = 0;
    set_trig(3, 1'b0);
    step(10);
    chk("R4 fall mode", 32'(hs), 1);
    wr_cfg(3, 0, 0, 3, 1);
    wr_cfg(3, 0, 1, 3, 1);
    hs = 0;
    set_trig(3, 1'b1);
    step(10);
    set_trig(3, 1'b0);
    step(10);
    chk("R4 both-edge mode", 32'(hs), 4);
    wr_cfg(3, 0, 0, 0, 0);
    wr_cfg(3, 0, 1, 0, 0);
    hs = 0;
    set_trig(3, 1'b1);
    step(5);
    set_trig(3, 1'b0);
    step(5);
    chk("R4 no-event mode", 32'(hs), 0);

    phase = "R11";
    wr_cfg(3, 0, 0, 1, 0);
    wr_cfg(3, 0, 1, 1, 0);
    hs = 0;
    set_trig(5, 1'b1);
    step(8);
    chk("R11 unselected line", 32'(hs), 0);
    set_trig(5, 1'b0);
    wr_cfg(5, 0, 1, 1, 0);
    set_trig(5, 1'b1);
    step(8);
    chk("R11 selected line", 32'(hs), 1);
    set_trig(5, 1'b0);

    phase = "R10"; rdy_mode = 2;
    set_trig(5, 1'b1);
    step(5);
    chk("R6 held without ready", 32'(req_valid), 1);
    wr_cfg(5, 0, 0, 1, 0);
    step(2);
    chk("R10 abort drops request", 32'(req_valid), 0);
    set_trig(5, 1'b0);
    set_trig(5, 1'b1);
    step(3);
    chk("R10 disabled ignores trigger", 32'(req_valid), 0);
    rdy_mode = 0; hs = 0;
    wr_cfg(5, 0, 1, 1, 0);
    step(10);
    chk("R10 no stale burst on re-enable", 32'(hs), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule